// File: doc/BRIEF.md
# Ethernet Receive Frame Classifier

This block sits behind a receive MAC whose frame check has already been done and whose check bytes have been removed. Frames come in one byte per cycle, with a valid strobe and a marker on the final byte. The block keeps only frames sent to the configured station address or to the broadcast address. It then chooses one of two destinations for each kept frame. A UDP datagram that is sent to the configured IPv4 address and to the dedicated port (1000 by default) has its payload streamed straight to a sample-stream receiver output. Every other kept frame loses its 14-byte Ethernet header, gets its 16-bit type field placed in front of the payload, and is written byte by byte into an external circular packet buffer.

The packet buffer is divided into equal slots, and each slot holds one packet. The number of slots is a whole number, so the last slot ends exactly at the top of the buffer and the slot index wraps back to zero there. For each packet that is stored completely, a command carrying the slot's 16-bit byte pointer and a 14-bit stored size is placed in an internal command FIFO. The consumer reads that command, processes the slot, and then returns the slot with a one-cycle release pulse.

Three kinds of frame are thrown away: frames longer than the standard limit, frames shorter than a full header, and frames that arrive when no slot or no command entry is free. Only the last kind advances a saturating drop counter.

Top module: `eth_rx_classifier`

## Requirements
- R1: A frame is kept only if its bytes 0..5 are equal to `local_mac`, with byte 0 compared against bits 47:40, or are all 0xFF. Any other frame produces no stream byte, no command and no abort.
- R2: For a frame that goes to the packet buffer, stored offset 0 is frame byte 12 and offset 1 is frame byte 13 (the type field, most significant byte first). Stored offset k, for k ≥ 2, is frame byte 12+k.
- R3: A kept frame goes to the stream output when all of these hold: the type field is 0x0800; the low nibble of byte 14 is 5; byte 23 is 17; bytes 30..33 are equal to `local_ip` with the most significant byte first; bytes 36..37 are equal to the UDP port parameter, big-endian; and a byte at offset 42 exists. Frame bytes 42 onward then appear on `strm_data`, one cycle after input, with `strm_last` set on the final byte. Nothing is stored for such a frame.
- R4: Every other kept frame of at least 14 bytes goes to the packet buffer and produces exactly one command. Frames of type 0x0806 and frames with a non-UDP protocol or a header length other than 5 words are among these. No stream byte appears for them.
- R5: A frame longer than `MAX_FRAME` bytes produces no command. If it was already streaming, a single `strm_abort` pulse takes the place of its first excess byte, and no `strm_last` follows.
- R6: Slots are taken in round-robin order, 0, 1, …, NUM_SLOTS−1, 0, and so on. `cmd_ptr` equals slot × `SLOT_BYTES`. A slot stays in use until a `slot_release` pulse frees it.
- R7: `cmd_size` equals frame length − 12. Commands leave the FIFO in arrival order, and `cmd_pop` removes the head entry.
- R8: When the first byte of a frame arrives while the command FIFO is full or every slot is in use, the whole frame is dropped and `drop_count` goes up by one. The counter stops at its all-ones value.
- R9: A kept frame shorter than 14 bytes is discarded without a command, without a stream byte and without changing `drop_count`.
- R10: A `slot_release` pulse while no slot is in use has no effect.
- R11: After reset, every output strobe is low, `cmd_valid` is low and `drop_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Input byte strobe |
| rx_data | input | 8 | Input frame byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| local_mac | input | 48 | Station MAC address, byte 0 in bits 47:40 |
| local_ip | input | 32 | Station IPv4 address, first byte in bits 31:24 |
| strm_valid | output | 1 | Stream payload byte strobe |
| strm_data | output | 8 | Stream payload byte |
| strm_last | output | 1 | Final payload byte of a streamed datagram |
| strm_abort | output | 1 | Streamed datagram cut off as oversize |
| buf_we | output | 1 | Packet buffer write enable |
| buf_addr | output | 16 | Packet buffer byte address |
| buf_wdata | output | 8 | Packet buffer write byte |
| cmd_valid | output | 1 | Command FIFO not empty |
| cmd_ptr | output | 16 | Head command: slot byte pointer |
| cmd_size | output | 14 | Head command: stored byte count |
| cmd_pop | input | 1 | Remove the head command |
| slot_release | input | 1 | Return the oldest slot in use |
| drop_count | output | DROP_W | Saturating count of admission drops |

## Verification
The admission drop is the hardest condition to reach from the ports. It needs the command FIFO or the slot ring to be exhausted at the exact moment a frame begins. The bench gets there by sending control frames without popping or releasing anything, so that the two-entry FIFO fills first. It then pops commands without releasing slots, so that the three-slot ring fills next. Each resource is exhausted on its own, and further drops push the three-bit counter past its limit. Before that, a sweep covers every address kind, every header defect and a set of lengths around the 14-byte, 42-byte and maximum boundaries.

// File: rtl/eth_cls_pkg.sv
package eth_cls_pkg;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_RUN,
        FS_STREAM,
        FS_DROP
    } frame_st_e;

    typedef struct packed {
        logic [15:0] ptr;
        logic [13:0] size;
    } cls_cmd_t;

    // byte offsets inside the frame that the classifier decodes
    localparam int OFS_ETYPE   = 12;
    localparam int OFS_VIHL    = 14;
    localparam int OFS_PROTO   = 23;
    localparam int OFS_DIP     = 30;
    localparam int OFS_DPORT   = 36;
    localparam int OFS_PAYLOAD = 42;
    localparam int MAC_BYTES   = 6;

    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [7:0]  PROTO_UDP  = 8'd17;
    localparam logic [3:0]  IHL_PLAIN  = 4'd5;

endpackage

// File: rtl/eth_cls_hdr_match.sv
module eth_cls_hdr_match
    import eth_cls_pkg::*;
#(
    parameter int IDX_W    = 11,
    parameter int UDP_PORT = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       data,
    input  logic [47:0]      cfg_mac,
    input  logic [31:0]      cfg_ip,
    output logic             mac_hit,
    output logic             udp_hit
);

    localparam logic [15:0] PORT_V = 16'(UDP_PORT);

    typedef struct packed {
        logic uc;
        logic bc;
        logic ipv4;
        logic ihl;
        logic proto;
        logic dip;
        logic port;
    } match_s;

    match_s q, d;

    function automatic logic [7:0] mac_byte(input logic [47:0] m, input int i);
        return 8'(m >> (8 * (MAC_BYTES - 1 - i)));
    endfunction

    function automatic logic [7:0] ip_byte(input logic [31:0] a, input int i);
        return 8'(a >> (8 * (3 - i)));
    endfunction

    always_comb begin
        int i;
        i = int'(idx);
        d = q;
        if (byte_en) begin
            if (i == 0) begin
                d = '{default: 1'b1};
            end
            if (i < MAC_BYTES) begin
                d.uc = d.uc & (data == mac_byte(cfg_mac, i));
                d.bc = d.bc & (data == 8'hFF);
            end
            if (i == OFS_ETYPE) begin
                d.ipv4 = d.ipv4 & (data == ETYPE_IPV4[15:8]);
            end
            if (i == OFS_ETYPE + 1) begin
                d.ipv4 = d.ipv4 & (data == ETYPE_IPV4[7:0]);
            end
            if (i == OFS_VIHL) begin
                d.ihl = d.ihl & (data[3:0] == IHL_PLAIN);
            end
            if (i == OFS_PROTO) begin
                d.proto = d.proto & (data == PROTO_UDP);
            end
            if (i >= OFS_DIP && i < OFS_DIP + 4) begin
                d.dip = d.dip & (data == ip_byte(cfg_ip, i - OFS_DIP));
            end
            if (i == OFS_DPORT) begin
                d.port = d.port & (data == PORT_V[15:8]);
            end
            if (i == OFS_DPORT + 1) begin
                d.port = d.port & (data == PORT_V[7:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mac_hit = q.uc | q.bc;
    assign udp_hit = q.ipv4 & q.ihl & q.proto & q.dip & q.port;

endmodule

// File: rtl/eth_cls_slots.sv
module eth_cls_slots #(
    parameter int NUM_SLOTS  = 16,
    parameter int SLOT_BYTES = 1536,
    parameter int PTR_W      = 16,
    parameter int DROP_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              release_i,
    input  logic              sof_drop,
    output logic [PTR_W-1:0]  slot_ptr,
    output logic              has_free,
    output logic [DROP_W-1:0] drop_count
);

    localparam int SW = $clog2(NUM_SLOTS);
    localparam int UW = $clog2(NUM_SLOTS + 1);
    localparam logic [SW-1:0] LAST_SLOT = SW'(NUM_SLOTS - 1);
    localparam logic [UW-1:0] ALL_USED  = UW'(NUM_SLOTS);

    typedef struct packed {
        logic [SW-1:0]     wslot;
        logic [UW-1:0]     used;
        logic [DROP_W-1:0] drops;
    } slot_s;

    slot_s q, d;
    logic  rel_ok;

    always_comb begin
        d      = q;
        rel_ok = release_i && (q.used != '0);
        if (commit) begin
            d.wslot = (q.wslot == LAST_SLOT) ? '0 : q.wslot + 1'b1;
        end
        d.used = q.used + UW'(commit) - UW'(rel_ok);
        if (sof_drop && (q.drops != '1)) begin
            d.drops = q.drops + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign slot_ptr   = PTR_W'(int'(q.wslot) * SLOT_BYTES);
    assign has_free   = (q.used != ALL_USED);
    assign drop_count = q.drops;

    p_used_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.used <= ALL_USED);

    p_commit_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (q.used < ALL_USED));

    p_drop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_drop && (q.drops != '1)) |=> (q.drops == $past(q.drops) + DROP_W'(1)));

    p_drop_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.drops == '1) |=> (q.drops == '1));

endmodule

// File: rtl/eth_cls_cmd_fifo.sv
module eth_cls_cmd_fifo
    import eth_cls_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  cls_cmd_t din,
    input  logic     pop,
    output logic     valid,
    output cls_cmd_t head,
    output logic     full
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    typedef struct packed {
        cls_cmd_t [DEPTH-1:0] mem;
        logic [AW-1:0]        wp;
        logic [AW-1:0]        rp;
        logic [CW-1:0]        cnt;
    } fifo_s;

    fifo_s q, d;
    logic  do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != CNT_MAX);
        do_pop  = pop && (q.cnt != '0);
        if (do_push) begin
            d.mem[q.wp] = din;
            d.wp        = (q.wp == LAST_IX) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == LAST_IX) ? '0 : q.rp + 1'b1;
        end
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign valid = (q.cnt != '0);
    assign head  = q.mem[q.rp];
    assign full  = (q.cnt == CNT_MAX);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_MAX);

endmodule

// File: rtl/eth_rx_classifier.sv
module eth_rx_classifier
    import eth_cls_pkg::*;
#(
    parameter int MAX_FRAME  = 1514,
    parameter int SLOT_BYTES = 1536,
    parameter int NUM_SLOTS  = 16,
    parameter int CMD_DEPTH  = 8,
    parameter int DROP_W     = 16,
    parameter int UDP_PORT   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic [47:0]       local_mac,
    input  logic [31:0]       local_ip,
    output logic              strm_valid,
    output logic [7:0]        strm_data,
    output logic              strm_last,
    output logic              strm_abort,
    output logic              buf_we,
    output logic [15:0]       buf_addr,
    output logic [7:0]        buf_wdata,
    output logic              cmd_valid,
    output logic [15:0]       cmd_ptr,
    output logic [13:0]       cmd_size,
    input  logic              cmd_pop,
    input  logic              slot_release,
    output logic [DROP_W-1:0] drop_count
);

    localparam int IDX_W = $clog2(MAX_FRAME + 2);
    localparam logic [IDX_W-1:0] IDX_OVER    = IDX_W'(MAX_FRAME);
    localparam logic [IDX_W-1:0] IDX_MACDONE = IDX_W'(MAC_BYTES);
    localparam logic [IDX_W-1:0] IDX_ETYPE   = IDX_W'(OFS_ETYPE);
    localparam logic [IDX_W-1:0] IDX_PAYLOAD = IDX_W'(OFS_PAYLOAD);
    localparam logic [IDX_W-1:0] IDX_MINLAST = IDX_W'(OFS_ETYPE + 1);
    localparam int BUF_BYTES = NUM_SLOTS * SLOT_BYTES;

    typedef struct packed {
        frame_st_e        st;
        logic [IDX_W-1:0] idx;
        logic             s_valid;
        logic [7:0]       s_data;
        logic             s_last;
        logic             s_abort;
        logic             we;
        logic [15:0]      addr;
        logic [7:0]       wdata;
    } cls_s;

    cls_s     q, d;
    logic     mac_hit, udp_hit;
    logic     has_free, fifo_full;
    logic     commit, sof_drop, over;
    logic [15:0] slot_ptr;
    cls_cmd_t push_cmd, head_cmd;

    eth_cls_hdr_match #(
        .IDX_W    (IDX_W),
        .UDP_PORT (UDP_PORT)
    ) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_en (rx_valid),
        .idx     (q.idx),
        .data    (rx_data),
        .cfg_mac (local_mac),
        .cfg_ip  (local_ip),
        .mac_hit (mac_hit),
        .udp_hit (udp_hit)
    );

    eth_cls_slots #(
        .NUM_SLOTS  (NUM_SLOTS),
        .SLOT_BYTES (SLOT_BYTES),
        .PTR_W      (16),
        .DROP_W     (DROP_W)
    ) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .release_i  (slot_release),
        .sof_drop   (sof_drop),
        .slot_ptr   (slot_ptr),
        .has_free   (has_free),
        .drop_count (drop_count)
    );

    eth_cls_cmd_fifo #(
        .DEPTH (CMD_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (commit),
        .din   (push_cmd),
        .pop   (cmd_pop),
        .valid (cmd_valid),
        .head  (head_cmd),
        .full  (fifo_full)
    );

    always_comb begin
        d         = q;
        d.s_valid = 1'b0;
        d.s_last  = 1'b0;
        d.s_abort = 1'b0;
        d.we      = 1'b0;
        commit    = 1'b0;
        sof_drop  = 1'b0;
        over      = (q.idx == IDX_OVER);
        push_cmd.ptr  = slot_ptr;
        push_cmd.size = 14'(q.idx - IDX_W'(OFS_ETYPE - 1));
        if (rx_valid) begin
            d.idx = over ? q.idx : q.idx + 1'b1;
            unique case (q.st)
                FS_IDLE: begin
                    if (!has_free || fifo_full) begin
                        sof_drop = 1'b1;
                        d.st     = FS_DROP;
                    end else begin
                        d.st = FS_RUN;
                    end
                end
                FS_RUN: begin
                    if (over) begin
                        d.st = FS_DROP;
                    end else if ((q.idx == IDX_MACDONE) && !mac_hit) begin
                        d.st = FS_DROP;
                    end else if ((q.idx == IDX_PAYLOAD) && udp_hit) begin
                        d.st      = FS_STREAM;
                        d.s_valid = 1'b1;
                        d.s_data  = rx_data;
                        d.s_last  = rx_last;
                    end else if (q.idx >= IDX_ETYPE) begin
                        d.we    = 1'b1;
                        d.addr  = slot_ptr + 16'(q.idx - IDX_ETYPE);
                        d.wdata = rx_data;
                        commit  = rx_last && (q.idx >= IDX_MINLAST);
                    end
                end
                FS_STREAM: begin
                    if (over) begin
                        d.s_abort = 1'b1;
                        d.st      = FS_DROP;
                    end else begin
                        d.s_valid = 1'b1;
                        d.s_data  = rx_data;
                        d.s_last  = rx_last;
                    end
                end
                default: begin
                    d.st = FS_DROP;
                end
            endcase
            if (rx_last) begin
                d.st  = FS_IDLE;
                d.idx = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= FS_IDLE;
        end else begin
            q <= d;
        end
    end

    assign strm_valid = q.s_valid;
    assign strm_data  = q.s_data;
    assign strm_last  = q.s_last;
    assign strm_abort = q.s_abort;
    assign buf_we     = q.we;
    assign buf_addr   = q.addr;
    assign buf_wdata  = q.wdata;
    assign cmd_ptr    = head_cmd.ptr;
    assign cmd_size   = head_cmd.size;

    p_route_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(strm_valid && buf_we));

    p_abort_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strm_abort |-> (!strm_valid && !strm_last));

    p_addr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (int'(buf_addr) < BUF_BYTES));

    p_cmd_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ((push_cmd.size >= 14'd2) && (int'(push_cmd.size) <= MAX_FRAME - OFS_ETYPE)));

    p_stream_after_hdr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (q.st == FS_STREAM)) |-> (q.idx > IDX_PAYLOAD));

endmodule

// File: tb/tb_eth_rx_classifier.sv
`timescale 1ns/1ps
module tb_eth_rx_classifier;

    localparam int MAXF   = 128;
    localparam int SLOTB  = 128;
    localparam int NSLOT  = 3;
    localparam int CDEPTH = 2;
    localparam int DW     = 3;
    localparam logic [47:0] MAC = 48'h021A_2B3C_4D5E;
    localparam logic [31:0] IP  = 32'hC0A8_0114;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0] rx_data = '0;
    logic cmd_pop = 1'b0, slot_release = 1'b0;
    logic strm_valid, strm_last, strm_abort, buf_we, cmd_valid;
    logic [7:0] strm_data, buf_wdata;
    logic [15:0] buf_addr, cmd_ptr;
    logic [13:0] cmd_size;
    logic [DW-1:0] drop_count;

    always #2.5 clk = ~clk;

    eth_rx_classifier #(
        .MAX_FRAME (MAXF), .SLOT_BYTES (SLOTB), .NUM_SLOTS (NSLOT),
        .CMD_DEPTH (CDEPTH), .DROP_W (DW), .UDP_PORT (1000)
    ) dut (
        .clk (clk), .rst_n (rst_n), .rx_valid (rx_valid), .rx_data (rx_data),
        .rx_last (rx_last), .local_mac (MAC), .local_ip (IP),
        .strm_valid (strm_valid), .strm_data (strm_data), .strm_last (strm_last),
        .strm_abort (strm_abort), .buf_we (buf_we), .buf_addr (buf_addr),
        .buf_wdata (buf_wdata), .cmd_valid (cmd_valid), .cmd_ptr (cmd_ptr),
        .cmd_size (cmd_size), .cmd_pop (cmd_pop), .slot_release (slot_release),
        .drop_count (drop_count)
    );

    int n_vec = 0, n_bad = 0;
    logic [7:0] frm [0:255];
    int flen;
    logic [7:0] bmem [0:NSLOT*SLOTB-1];
    logic [7:0] sbuf [0:255];
    int scnt, slast, sabort;

    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_we && int'(buf_addr) < NSLOT*SLOTB) bmem[buf_addr] = buf_wdata;
            if (strm_valid && scnt < 256) begin sbuf[scnt] = strm_data; scnt++; end
            if (strm_last) slast++;
            if (strm_abort) sabort++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mk: 0 local, 1 broadcast, 2 local with one byte altered
    task automatic build(input int mk, input int typ, input int len);
        for (int i = 0; i < 256; i++) frm[i] = 8'(i * 13 + len);
        for (int i = 0; i < 6; i++) begin
            frm[i] = (mk == 1) ? 8'hFF : 8'(MAC >> (8 * (5 - i)));
        end
        if (mk == 2) frm[typ % 6] = frm[typ % 6] ^ 8'h40;
        frm[12] = 8'h08; frm[13] = 8'h00;
        if (typ == 5) frm[13] = 8'h06;
        if (typ == 6) begin frm[12] = 8'h86; frm[13] = 8'hDD; end
        frm[14] = (typ == 4) ? 8'h46 : 8'h45;
        frm[23] = (typ == 3) ? 8'd6 : 8'd17;
        for (int i = 0; i < 4; i++) frm[30 + i] = 8'(IP >> (8 * (3 - i)));
        if (typ == 2) frm[33] = frm[33] + 8'd1;
        frm[36] = 8'h03;
        frm[37] = (typ == 1) ? 8'hE9 : 8'hE8;
        for (int i = 42; i < 256; i++) frm[i] = 8'(i * 7 + typ * 3 + mk);
        flen = len;
    endtask

    task automatic send(input bit gaps);
        scnt = 0; slast = 0; sabort = 0;
        for (int i = 0; i < flen; i++) begin
            if (gaps && (i % 5 == 2)) begin
                @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
            end
            @(negedge clk);
            rx_valid = 1'b1; rx_data = frm[i]; rx_last = (i == flen - 1);
        end
        @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pop_rel(input bit pop, input bit rel);
        @(negedge clk); cmd_pop = pop; slot_release = rel;
        @(negedge clk); cmd_pop = 1'b0; slot_release = 1'b0;
    endtask

    task automatic chk_ctrl(input string req, input int slot);
        int bad;
        chk(cmd_valid == 1'b1, req, int'(cmd_valid), 1);
        chk(int'(cmd_ptr) == slot * SLOTB, "R6 pointer", int'(cmd_ptr), slot * SLOTB);
        chk(int'(cmd_size) == flen - 12, "R7 size", int'(cmd_size), flen - 12);
        bad = 0;
        for (int k = 0; k < flen - 12; k++) if (bmem[slot * SLOTB + k] !== frm[12 + k]) bad++;
        chk(bad == 0, "R2 stored bytes", bad, 0);
        chk(scnt == 0, "R4 no stream", scnt, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int lens [10] = '{6, 13, 14, 20, 41, 42, 43, 128, 129, 140};
        int es;
        es = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!strm_valid && !strm_last && !strm_abort && !buf_we, "R11 strobes", 0, 0);
        chk(cmd_valid == 1'b0, "R11 cmd_valid", int'(cmd_valid), 0);
        chk(drop_count == '0, "R11 drop_count", int'(drop_count), 0);

        for (int mk = 0; mk < 3; mk++) begin
            for (int typ = 0; typ < 7; typ++) begin
                for (int li = 0; li < 10; li++) begin
                    bit macok, scls;
                    int bad, n;
                    build(mk, typ, lens[li]);
                    send(mk == 1);
                    macok = (mk < 2);
                    scls  = macok && (typ == 0) && (flen >= 43);
                    if (!macok || flen < 14) begin
                        chk(!cmd_valid && scnt == 0 && sabort == 0, macok ? "R9 short" : "R1 filtered",
                            int'(cmd_valid) + scnt + sabort, 0);
                    end else if (scls) begin
                        n = ((flen < MAXF) ? flen : MAXF) - 42;
                        chk(scnt == n, "R3 stream count", scnt, n);
                        bad = 0;
                        for (int k = 0; k < n; k++) if (sbuf[k] !== frm[42 + k]) bad++;
                        chk(bad == 0, "R3 stream bytes", bad, 0);
                        chk(slast == ((flen <= MAXF) ? 1 : 0), "R3 last", slast, (flen <= MAXF) ? 1 : 0);
                        chk(sabort == ((flen > MAXF) ? 1 : 0), "R5 abort", sabort, (flen > MAXF) ? 1 : 0);
                        chk(!cmd_valid, "R3 no command", int'(cmd_valid), 0);
                    end else if (flen > MAXF) begin
                        chk(!cmd_valid && scnt == 0, "R5 oversize dropped", int'(cmd_valid) + scnt, 0);
                    end else begin
                        chk_ctrl("R4 control command", es);
                        pop_rel(1'b1, 1'b1);
                        es = (es + 1) % NSLOT;
                    end
                end
            end
        end
        chk(drop_count == '0, "R8 no drops in sweep", int'(drop_count), 0);

        // R8: FIFO full, then slot ring full
        build(0, 5, 30); send(1'b0);
        build(0, 6, 31); send(1'b0);
        build(0, 5, 32); send(1'b0);
        chk(int'(drop_count) == 1, "R8 fifo full drop", int'(drop_count), 1);
        chk(cmd_valid && int'(cmd_ptr) == es * SLOTB && int'(cmd_size) == 18, "R7 head order",
            int'(cmd_size), 18);
        pop_rel(1'b1, 1'b0);
        chk(cmd_valid && int'(cmd_size) == 19, "R7 second entry", int'(cmd_size), 19);
        build(0, 3, 33); send(1'b0);
        pop_rel(1'b1, 1'b0);
        chk(cmd_valid && int'(cmd_ptr) == ((es + 2) % NSLOT) * SLOTB, "R6 third slot",
            int'(cmd_ptr), ((es + 2) % NSLOT) * SLOTB);
        build(0, 5, 34); send(1'b0);
        chk(int'(drop_count) == 2, "R8 no slot drop", int'(drop_count), 2);
        for (int j = 0; j < 6; j++) begin build(1, 5, 20 + j); send(1'b0); end
        chk(drop_count == '1, "R8 saturation", int'(drop_count), 7);

        // R10: free everything, extra releases ignored
        pop_rel(1'b1, 1'b1); pop_rel(1'b0, 1'b1); pop_rel(1'b0, 1'b1);
        pop_rel(1'b0, 1'b1); pop_rel(1'b0, 1'b1);
        chk(!cmd_valid, "R10 fifo empty", int'(cmd_valid), 0);
        for (int j = 0; j < 3; j++) begin
            build(0, 6, 40 + j); send(1'b0);
            chk_ctrl("R10 slot reuse", (es + j) % NSLOT);
            pop_rel(1'b1, 1'b0);
        end
        build(0, 6, 50); send(1'b0);
        chk(!cmd_valid, "R10 extra release ignored", int'(cmd_valid), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule